// File: doc/BRIEF.md
# Transmit Queue with Space-Bid Encoding

This block is a synchronous first-in first-out store for outgoing characters, 256 entries deep and 8 bits wide. A producer pushes characters through a write port and a serial engine pulls them from a read port. The read port is first-word-fall-through: the oldest stored character is always on the read data output. Full and empty flags guard both sides.

Alongside the data path, the queue presents a bid to an external interrupt arbiter. The bid value tells the arbiter how much room is left: it is the number of free slots minus one. An empty queue therefore bids 255 and a queue with a single free slot bids 0. A full queue never bids. A 2-bit level input chooses how full the queue may be and still bid, so that software is interrupted only once there is enough room to make a service pass worthwhile. The bid is registered, so it follows the occupancy with one clock of lag.

Top module: `txq_bid_fifo`

## Requirements
- R1: Characters leave in the order they were accepted, and while the queue is not empty `rd_data` shows the oldest stored character with no read latency.
- R2: `full` is high exactly when 256 characters are stored and `empty` is high exactly when none are stored.
- R3: While `bid_valid` is high, `bid_value` equals 255 minus the occupancy. While `bid_valid` is low, `bid_value` is 0.
- R4: When the occupancy is 256, the next bid has `bid_valid` low whatever the level input.
- R5: Level code 2'b00 bids whenever at least one slot is free.
- R6: Level code 2'b01 bids only when the queue is empty.
- R7: Level code 2'b10 bids when 16 or fewer characters are stored.
- R8: Level code 2'b11 bids when 240 or fewer characters are stored.
- R9: A write while full leaves the contents unchanged, and a read while empty leaves the occupancy unchanged.
- R10: An accepted read together with an accepted write in one cycle leaves the occupancy unchanged.
- R11: The bid is registered: after a clock edge it reflects the occupancy and level that held before that edge, so it trails an occupancy change by exactly one cycle.
- R12: Synchronous active-high reset empties the queue and clears the bid (`bid_valid` and `bid_value` both 0 on the first cycle after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 8 | Character to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 8 | Oldest stored character |
| full | output | 1 | All 256 slots occupied |
| empty | output | 1 | No slot occupied |
| bid_level | input | 2 | Fill condition under which bidding is allowed |
| bid_valid | output | 1 | Bid present for the arbiter |
| bid_value | output | 8 | Free slots minus one while bidding, else 0 |

## Verification
A corrupted occupancy count shows up at the ports within one cycle as a wrong `full` or `empty` flag, and one cycle later as a bid value off by the same amount; a pointer fault shows up on `rd_data` as soon as the affected slot reaches the head of the queue. A wrong level decode is visible one cycle after the occupancy crosses 16 or 240 entries, or leaves zero, while that level is selected. The bench therefore sweeps every level across the full range of occupancies, including the full and empty edges, and compares each cycle against a queue model.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int TXQ_DEPTH      = 256;
    localparam int TXQ_WIDTH      = 8;
    localparam int TXQ_LOW_MARK   = 16;
    localparam int TXQ_HIGH_MARK  = 240;

    typedef enum logic [1:0] {
        LVL_ANY_ROOM   = 2'b00,
        LVL_ONLY_EMPTY = 2'b01,
        LVL_LOW_FILL   = 2'b10,
        LVL_HIGH_FILL  = 2'b11
    } bid_level_e;

    typedef struct packed {
        logic full;
        logic empty;
    } fill_flags_t;

    typedef struct packed {
        logic push;
        logic pop;
    } accept_t;

    // Advance a ring pointer, wrapping at the last slot.
    function automatic logic [15:0] ring_next(input logic [15:0] ptr,
                                              input int unsigned depth);
        if (ptr == 16'(depth - 1)) return '0;
        return ptr + 16'd1;
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs
    import txq_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ,
    output fill_flags_t   flags,
    output accept_t       acc
);

    localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] occ_q;

    always_comb begin
        flags.full  = (occ_q == OCC_FULL);
        flags.empty = (occ_q == '0);
        acc.push    = push_req && !flags.full;
        acc.pop     = pop_req  && !flags.empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (acc.push) wr_ptr_q <= AW'(ring_next(16'(wr_ptr_q), DEPTH));
            if (acc.pop)  rd_ptr_q <= AW'(ring_next(16'(rd_ptr_q), DEPTH));
            unique case ({acc.push, acc.pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;
    assign occ    = occ_q;

endmodule

// File: rtl/txq_bid.sv
module txq_bid
    import txq_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int LOW_MARK  = 16,
    parameter int HIGH_MARK = 240,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int BW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    level,
    input  logic [CW-1:0] occ,
    output logic          bid_valid,
    output logic [BW-1:0] bid_value
);

    localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] OCC_LOW  = CW'(LOW_MARK);
    localparam logic [CW-1:0] OCC_HIGH = CW'(HIGH_MARK);
    localparam logic [BW-1:0] TOP_VAL  = BW'(DEPTH - 1);

    bid_level_e    lvl;
    logic          gate_d;
    logic [BW-1:0] value_d;
    logic          valid_q;
    logic [BW-1:0] value_q;

    assign lvl = bid_level_e'(level);

    always_comb begin
        unique case (lvl)
            LVL_ANY_ROOM:   gate_d = (occ != OCC_FULL);
            LVL_ONLY_EMPTY: gate_d = (occ == '0);
            LVL_LOW_FILL:   gate_d = (occ <= OCC_LOW);
            LVL_HIGH_FILL:  gate_d = (occ <= OCC_HIGH);
            default:        gate_d = 1'b0;
        endcase
        // Never bid when every slot is taken, whatever the marks say.
        if (occ == OCC_FULL) gate_d = 1'b0;
        value_d = gate_d ? (TOP_VAL - occ[BW-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            value_q <= '0;
        end else begin
            valid_q <= gate_d;
            value_q <= value_d;
        end
    end

    assign bid_valid = valid_q;
    assign bid_value = value_q;

endmodule

// File: rtl/txq_bid_fifo.sv
module txq_bid_fifo
    import txq_pkg::*;
#(
    parameter int WIDTH     = TXQ_WIDTH,
    parameter int DEPTH     = TXQ_DEPTH,
    parameter int LOW_MARK  = TXQ_LOW_MARK,
    parameter int HIGH_MARK = TXQ_HIGH_MARK,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int BW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    input  logic [1:0]       bid_level,
    output logic             bid_valid,
    output logic [BW-1:0]    bid_value
);

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ_q;
    fill_flags_t   flags;
    accept_t       acc;

    txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push_req (wr_en),
        .pop_req  (rd_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ_q),
        .flags    (flags),
        .acc      (acc)
    );

    txq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (acc.push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    txq_bid #(
        .DEPTH     (DEPTH),
        .LOW_MARK  (LOW_MARK),
        .HIGH_MARK (HIGH_MARK)
    ) u_bid (
        .clk       (clk),
        .rst       (rst),
        .level     (bid_level),
        .occ       (occ_q),
        .bid_valid (bid_valid),
        .bid_value (bid_value)
    );

    assign full  = flags.full;
    assign empty = flags.empty;

endmodule

// File: rtl/txq_bid_fifo_chk.sv
module txq_bid_fifo_chk #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic [1:0]    bid_level,
    input logic [CW-1:0] occ,
    input logic          bid_valid,
    input logic [BW-1:0] bid_value
);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    p_full_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && $stable(occ)));

    p_empty_read_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(occ)));

    p_balanced_r10: assert property (@(posedge clk) disable iff (rst)
        (!full && !empty && wr_en && rd_en) |=> $stable(occ));

    p_full_no_bid_r4: assert property (@(posedge clk) disable iff (rst)
        $past(full) |-> !bid_valid);

    p_bid_value_r3: assert property (@(posedge clk) disable iff (rst)
        bid_valid |-> (bid_value == BW'(DEPTH - 1) - $past(occ[BW-1:0])));

    p_idle_value_r3: assert property (@(posedge clk) disable iff (rst)
        !bid_valid |-> (bid_value == '0));

    p_only_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (bid_valid && $past(bid_level) == 2'b01) |-> $past(empty));

    p_reset_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bid_valid && empty));

endmodule

bind txq_bid_fifo txq_bid_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .full      (full),
    .empty     (empty),
    .bid_level (bid_level),
    .occ       (occ_q),
    .bid_valid (bid_valid),
    .bid_value (bid_value)
);

// File: tb/txq_bid_fifo_bench.sv
module txq_bid_fifo_bench;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] bid_level = 2'b00;
    logic [7:0] rd_data;
    logic       full, empty, bid_valid;
    logic [7:0] bid_value;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [7:0] q[$];
    logic       m_valid = 1'b0;
    logic [7:0] m_value = 8'h00;
    string      m_tag   = "R12";

    always #2 clk = ~clk;

    txq_bid_fifo u_txq_bid_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .full      (full),
        .empty     (empty),
        .bid_level (bid_level),
        .bid_valid (bid_valid),
        .bid_value (bid_value)
    );

    function automatic bit may_bid(int fill, logic [1:0] lv);
        if (fill >= DEPTH) return 1'b0;
        case (lv)
            2'b00:   return 1'b1;
            2'b01:   return fill == 0;
            2'b10:   return fill <= 16;
            default: return fill <= 240;
        endcase
    endfunction

    function automatic string level_tag(int fill, logic [1:0] lv);
        if (fill >= DEPTH) return "R4";
        case (lv)
            2'b00:   return "R5";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Model update on the same edge the design uses
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_valid = 1'b0;
            m_value = 8'h00;
            m_tag   = "R12";
        end else begin
            automatic int  fill  = q.size();
            automatic bit  do_wr = wr_en && (fill < DEPTH);
            automatic bit  do_rd = rd_en && (fill > 0);
            m_valid = may_bid(fill, bid_level);
            m_value = m_valid ? 8'(255 - fill) : 8'h00;
            m_tag   = level_tag(fill, bid_level);
            if (do_rd) void'(q.pop_front());
            if (do_wr) q.push_back(wr_data);
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 full",  32'(full),  32'(q.size() == DEPTH));
            check("R2 empty", 32'(empty), 32'(q.size() == 0));
            if (q.size() > 0) check("R1 rd_data", 32'(rd_data), 32'(q[0]));
            check({m_tag, " bid_valid"}, 32'(bid_valid), 32'(m_valid));
            check("R3 bid_value", 32'(bid_value), 32'(m_value));
        end
    end

    task automatic step(bit w, bit r, logic [7:0] d, logic [1:0] lv);
        @(posedge clk);
        #1;
        wr_en     = w;
        rd_en     = r;
        wr_data   = d;
        bid_level = lv;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check("R12 empty",     32'(empty),     32'd1);
        check("R12 full",      32'(full),      32'd0);
        check("R12 bid_valid", 32'(bid_valid), 32'd0);
        check("R12 bid_value", 32'(bid_value), 32'd0);

        // R11: bid trails a push by one cycle (level 01, empty-only)
        step(0, 0, 8'h00, 2'b01);
        step(1, 0, 8'hA5, 2'b01);
        step(0, 0, 8'h00, 2'b01);
        @(negedge clk);
        check("R11 bid still up after push", 32'(bid_valid), 32'd1);
        check("R11 queue no longer empty",   32'(empty),     32'd0);
        step(0, 0, 8'h00, 2'b01);
        @(negedge clk);
        check("R11 bid drops one cycle later", 32'(bid_valid), 32'd0);

        // Level 00: fill partly, then balanced traffic (R10)
        for (int i = 0; i < 20; i++) step(1, 0, 8'(i * 7 + 1), 2'b00);
        for (int i = 0; i < 10; i++) step(1, 1, 8'(i + 100), 2'b00);
        step(0, 0, 8'h00, 2'b00);
        @(negedge clk);
        check("R10 occupancy kept under balanced traffic", 32'(bid_value), 32'(255 - 21));

        // Level 10 across the 16 mark, then drain to empty
        for (int i = 0; i < 8; i++) step(0, 1, 8'h00, 2'b10);
        for (int i = 0; i < 16; i++) step(0, 1, 8'h00, 2'b10);

        // Fill to full at level 11 (crosses 240)
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 8'(i ^ 8'h3C), 2'b11);
        step(0, 0, 8'h00, 2'b11);
        @(negedge clk);
        check("R9 full after overfill", 32'(full), 32'd1);
        check("R9 head kept after overfill", 32'(rd_data), 32'(q[0]));
        // R4: no level bids at full
        for (int l = 0; l < 4; l++) step(0, 0, 8'h00, 2'(l));
        step(0, 0, 8'h00, 2'b00);
        @(negedge clk);
        check("R4 no bid when full", 32'(bid_valid), 32'd0);
        // Push and pop together while full: only the pop is taken
        step(1, 1, 8'hEE, 2'b00);
        step(0, 0, 8'h00, 2'b00);

        // Drain at level 11 then 01, then read while empty
        for (int i = 0; i < 30; i++) step(0, 1, 8'h00, 2'b11);
        for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00, 2'b01);
        step(0, 1, 8'h00, 2'b01);
        step(0, 0, 8'h00, 2'b01);
        @(negedge clk);
        check("R9 empty after over-read", 32'(empty), 32'd1);
        // Push and pop together while empty: only the push is taken
        step(1, 1, 8'h5A, 2'b00);
        step(0, 0, 8'h00, 2'b00);
        @(negedge clk);
        check("R9 push taken with pop on empty", 32'(rd_data), 32'h5A);

        // Mixed traffic at all levels
        for (int i = 0; i < 4000; i++) begin
            automatic int phase = (i / 500) % 2;
            automatic bit w = phase == 0 ? ($urandom_range(0, 9) < 7) : ($urandom_range(0, 9) < 3);
            automatic bit r = phase == 0 ? ($urandom_range(0, 9) < 3) : ($urandom_range(0, 9) < 7);
            step(w, r, 8'($urandom), 2'((i / 97) % 4));
        end
        step(0, 0, 8'h00, 2'b00);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule